// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the register-mapped control unit of a multi-channel successive-approximation converter that runs in software-started single-channel mode. Software picks one channel through a one-hot mask. It sets the sampling and compare times, switches the converter on, and then sets an enable bit to launch a conversion. Busy stays high for the programmed conversion time. At the end, the 12-bit result lands in that channel's result register. The channel's done flag and, if enabled, an interrupt are then raised.

The analog core is modelled by a digital stand-in. It samples the `ana_in` bus when a conversion starts and hands the value back at the end. An invalid channel mask stops the conversion from starting and raises a select-error flag instead. A software reset bit puts every register back to its default value at once.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the registers read as follows: control (0x00) = 0, mode (0x04) = 0, mask (0x08) = 0, timing (0x0C) = 0x000E0578 (sampling period in bits 15:0, compare time in bits 23:16), interrupt control (0x20) = 0, status (0x24) = 0, divider (0x28) = 4, and every result register (0x30 + 4*ch) = 0. The `irq` output is 0.
- R2: Writing control with bit 2 (power) already 1 and bit 0 (enable) = 1, while the mask has exactly one bit set, starts a conversion. From the next cycle, control bits 0 and 1 (busy) read 1 for exactly max(1, smp+cmp) * 4 cycles, and then both read 0.
- R3: When a conversion finishes, result register 0x30 + 4*ch holds the `ana_in` value that was present at the start write, in bits 11:0 with zeros above. Status bit ch (done) is set.
- R4: An enable write whose mask has zero bits or more than one bit set starts no conversion: busy and enable stay 0 and the result registers do not change. Status bit 16 (select error) is set instead.
- R5: In status, writing 1 clears a bit and writing 0 leaves it unchanged. If a conversion finishes in the same cycle as a write of 1 to its done bit, the done bit stays set.
- R6: With interrupt control bit 31 = 1 (level), `irq` is 1 exactly while some status done bit has its enable set (bits NCH-1:0) or the error flag is set with bit 16 enabled.
- R7: With interrupt control bit 31 = 0 (pulse), each newly set enabled flag gives a single-cycle `irq` pulse in the cycle the flag first reads 1.
- R8: While the power bit is 0, an enable write has no effect: busy, enable, status and results stay unchanged.
- R9: Writing control with enable = 0 while busy aborts the conversion. Busy and enable read 0 in the next cycle, and no done flag or result is written.
- R10: Writing control with bit 15 = 1 returns all registers to their R1 values in the next cycle and aborts any conversion. Bit 15 then reads 1 until control is written with bit 15 = 0.
- R11: The divider register accepts only the value 4, and any other write leaves it unchanged. Timing bits 31:24 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ana_in | input | 12 | Value returned by the converter stand-in |
| irq | output | 1 | Interrupt, level or pulse as configured |

## Verification
Two events can fall on the same clock edge: a conversion finishing, and a software write to the status register or to the enable bit. The bench computes the exact finish edge from the programmed sampling and compare times. It then places a write of 1 to the finishing channel's done bit on that edge and expects the flag to read 1 afterwards. Randomized conversions on random channels, with random timing and random values, check the busy length, result, flag and interrupt behaviour against bench-side formulas.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int unsigned RES_W     = 12;
    localparam int unsigned SMP_W     = 16;
    localparam int unsigned CMP_W     = 8;
    localparam int unsigned DIV_W     = 9;
    localparam int unsigned TICK_W    = SMP_W + 1;

    localparam logic [7:0] A_CTL      = 8'h00;
    localparam logic [7:0] A_MODE     = 8'h04;
    localparam logic [7:0] A_MASK     = 8'h08;
    localparam logic [7:0] A_TIME     = 8'h0C;
    localparam logic [7:0] A_INTC     = 8'h20;
    localparam logic [7:0] A_STAT     = 8'h24;
    localparam logic [7:0] A_DIV      = 8'h28;
    localparam logic [7:0] A_RES0     = 8'h30;

    localparam int unsigned B_EN      = 0;
    localparam int unsigned B_BUSY    = 1;
    localparam int unsigned B_PWR     = 2;
    localparam int unsigned B_SRST    = 15;
    localparam int unsigned B_ERR     = 16;
    localparam int unsigned B_LVL     = 31;

    localparam logic [SMP_W-1:0] SMP_RST = 16'h0578;
    localparam logic [CMP_W-1:0] CMP_RST = 8'h0E;
    localparam logic [DIV_W-1:0] DIV_RST = 9'd4;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int unsigned DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             wrap;

    always_comb begin
        wrap  = (div <= 1) || (cnt_q >= div - 1'b1);
        cnt_d = cnt_q;
        if (clear)     cnt_d = '0;
        else if (wrap) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    assign tick = wrap && !clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
    parameter int unsigned TICK_W = 17,
    parameter int unsigned RES_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              tick,
    input  logic [TICK_W-1:0] ticks,
    input  logic [RES_W-1:0]  ana_in,
    output logic              busy,
    output logic              last,
    output logic [RES_W-1:0]  sample
);
    typedef struct packed {
        logic              busy;
        logic [TICK_W-1:0] left;
        logic [RES_W-1:0]  sample;
    } stub_t;

    stub_t s_d, s_q;

    assign last = s_q.busy && tick && (s_q.left == 1);

    always_comb begin
        s_d = s_q;
        if (abort) begin
            s_d.busy = 1'b0;
        end else if (start) begin
            s_d.busy   = 1'b1;
            s_d.left   = (ticks == '0) ? TICK_W'(1) : ticks;
            s_d.sample = ana_in;
        end else if (s_q.busy && tick) begin
            if (s_q.left == 1) s_d.busy = 1'b0;
            else               s_d.left = s_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy   = s_q.busy;
    assign sample = s_q.sample;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [RES_W-1:0]  ana_in,
    output logic              irq
);
    localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic                       en;
        logic                       pwr;
        logic                       srst;
        logic                       m_trg;
        logic                       m_sel;
        logic                       m_bufm;
        logic [1:0]                 m_edge;
        logic [NCH-1:0]             mask;
        logic [SMP_W-1:0]           smp;
        logic [CMP_W-1:0]           cmp;
        logic                       lvl;
        logic                       err_ie;
        logic [NCH-1:0]             ie;
        logic [NCH-1:0]             done;
        logic                       err;
        logic [DIV_W-1:0]           div;
        logic [CHW-1:0]             ch;
        logic [NCH-1:0][RES_W-1:0]  res;
        logic                       pulse;
    } regs_t;

    function automatic regs_t regs_default();
        regs_t r;
        r     = '0;
        r.smp = SMP_RST;
        r.cmp = CMP_RST;
        r.div = DIV_RST;
        return r;
    endfunction

    regs_t s_d, s_q;

    logic              busy_w, last_w, tick_w;
    logic [RES_W-1:0]  sample_w;
    logic              go, kill, srst_wr, ctl_wr;
    logic [CHW-1:0]    sel_idx;
    logic [NCH-1:0]    new_done;
    logic              new_err;

    assign ctl_wr  = bus_wr && (bus_addr == A_CTL);
    assign srst_wr = ctl_wr && bus_wdata[B_SRST];

    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (s_q.mask[i]) sel_idx = CHW'(i);
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        go        = 1'b0;
        kill      = 1'b0;

        if (bus_wr) begin
            unique case (bus_addr)
                A_CTL: begin
                    s_d.pwr  = bus_wdata[B_PWR];
                    s_d.srst = 1'b0;
                    if (bus_wdata[B_EN] && !s_q.en && s_q.pwr) begin
                        if ($onehot(s_q.mask)) begin
                            s_d.en = 1'b1;
                            s_d.ch = sel_idx;
                            go     = 1'b1;
                        end else begin
                            s_d.err = 1'b1;
                        end
                    end else if (!bus_wdata[B_EN] && s_q.en) begin
                        s_d.en = 1'b0;
                        kill   = 1'b1;
                    end
                end
                A_MODE: begin
                    s_d.m_trg  = bus_wdata[0];
                    s_d.m_sel  = bus_wdata[2];
                    s_d.m_bufm = bus_wdata[4];
                    s_d.m_edge = bus_wdata[13:12];
                end
                A_MASK: s_d.mask = bus_wdata[NCH-1:0];
                A_TIME: begin
                    s_d.smp = bus_wdata[SMP_W-1:0];
                    s_d.cmp = bus_wdata[16 +: CMP_W];
                end
                A_INTC: begin
                    s_d.lvl    = bus_wdata[B_LVL];
                    s_d.err_ie = bus_wdata[B_ERR];
                    s_d.ie     = bus_wdata[NCH-1:0];
                end
                A_STAT: begin
                    s_d.done = s_q.done & ~bus_wdata[NCH-1:0];
                    s_d.err  = s_q.err  & ~bus_wdata[B_ERR];
                end
                A_DIV: begin
                    if (bus_wdata[DIV_W-1:0] == DIV_RST) s_d.div = DIV_RST;
                end
                default: ;
            endcase
        end

        // completion overrides a same-cycle clear of its own flag
        if (last_w) begin
            s_d.en           = 1'b0;
            s_d.res[s_q.ch]  = sample_w;
            s_d.done[s_q.ch] = 1'b1;
            kill             = 1'b0;
        end

        new_done  = s_d.done & ~s_q.done & s_d.ie;
        new_err   = s_d.err & ~s_q.err & s_d.err_ie;
        s_d.pulse = !s_d.lvl && ((|new_done) || new_err);

        if (srst_wr) begin
            s_d      = regs_default();
            s_d.srst = 1'b1;
            go       = 1'b0;
            kill     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= regs_default();
        else        s_q <= s_d;
    end

    adc_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (go),
        .div   (s_q.div),
        .tick  (tick_w)
    );

    adc_conv_stub #(.TICK_W(TICK_W), .RES_W(RES_W)) u_stub (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (go),
        .abort  (kill),
        .tick   (tick_w),
        .ticks  (TICK_W'(s_q.smp) + TICK_W'(s_q.cmp)),
        .ana_in (ana_in),
        .busy   (busy_w),
        .last   (last_w),
        .sample (sample_w)
    );

    assign irq = s_q.lvl ? ((|(s_q.done & s_q.ie)) || (s_q.err && s_q.err_ie)) : s_q.pulse;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTL: begin
                bus_rdata[B_EN]   = s_q.en;
                bus_rdata[B_BUSY] = busy_w;
                bus_rdata[B_PWR]  = s_q.pwr;
                bus_rdata[B_SRST] = s_q.srst;
            end
            A_MODE: begin
                bus_rdata[0]     = s_q.m_trg;
                bus_rdata[2]     = s_q.m_sel;
                bus_rdata[4]     = s_q.m_bufm;
                bus_rdata[13:12] = s_q.m_edge;
            end
            A_MASK: bus_rdata[NCH-1:0] = s_q.mask;
            A_TIME: begin
                bus_rdata[SMP_W-1:0]  = s_q.smp;
                bus_rdata[16 +: CMP_W] = s_q.cmp;
            end
            A_INTC: begin
                bus_rdata[B_LVL]     = s_q.lvl;
                bus_rdata[B_ERR]     = s_q.err_ie;
                bus_rdata[NCH-1:0]   = s_q.ie;
            end
            A_STAT: begin
                bus_rdata[B_ERR]     = s_q.err;
                bus_rdata[NCH-1:0]   = s_q.done;
            end
            A_DIV: bus_rdata[DIV_W-1:0] = s_q.div;
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (bus_addr == A_RES0 + 8'(4 * i)) bus_rdata[RES_W-1:0] = s_q.res[i];
                end
            end
        endcase
    end

    // R2: the converter is only busy while the enable bit is held
    p_busy_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |-> s_q.en);

    // R3: a finishing conversion leaves its done flag set
    p_finish_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_w && !srst_wr) |=> s_q.done[$past(s_q.ch)]);

    // R4: a bad mask never starts the converter
    p_badmask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[B_EN] && !bus_wdata[B_SRST] && s_q.pwr && !s_q.en
         && !$onehot(s_q.mask)) |=> (!busy_w && s_q.err));

    // R8: no start while powered down
    p_nopwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[B_EN] && !s_q.pwr && !busy_w) |=> !busy_w);

    // R9: clearing enable while busy stops the converter
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !bus_wdata[B_EN] && busy_w && !last_w) |=> (!busy_w && !s_q.en));

    // R10: software reset restores defaults and stops the converter
    p_srst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> (!busy_w && s_q.srst && s_q.mask == '0 && s_q.div == DIV_RST));
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] ana_in = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [11:0] mirror [8];

    always #5 clk = ~clk;

    adc_seq_ctrl #(.NCH(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ana_in(ana_in), .irq(irq)
    );

    function automatic int exp_cycles(int smp, int cmp);
        int n;
        n = smp + cmp;
        if (n == 0) n = 1;
        return n * 4;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run_conv(int ch, int smp, int cmp, logic [11:0] val,
                            output int cyc, output int irqs);
        logic [31:0] d;
        wr(8'h08, 32'(1) << ch);
        wr(8'h0C, (32'(cmp) << 16) | 32'(smp));
        ana_in = val;
        wr(8'h00, 32'h5);
        ana_in = ~val;
        cyc = 0; irqs = 0;
        rd(8'h00, d);
        while (d[1]) begin
            if (irq) irqs++;
            cyc++;
            @(negedge clk);
            rd(8'h00, d);
        end
        if (irq) irqs++;
        @(negedge clk);
        if (irq) irqs++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cyc, irqs;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 8; i++) mirror[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(8'h00, d); chk("R1 ctl", d, 32'h0);
        rd(8'h04, d); chk("R1 mode", d, 32'h0);
        rd(8'h08, d); chk("R1 mask", d, 32'h0);
        rd(8'h0C, d); chk("R1 timing", d, 32'h000E0578);
        rd(8'h20, d); chk("R1 intc", d, 32'h0);
        rd(8'h24, d); chk("R1 status", d, 32'h0);
        rd(8'h28, d); chk("R1 div", d, 32'h4);
        for (int i = 0; i < 8; i++) begin
            rd(8'(8'h30 + 4 * i), d); chk("R1 result", d, 32'h0);
        end
        chk("R1 irq", 32'(irq), 32'h0);

        // R8 enable while powered down
        wr(8'h08, 32'h1);
        wr(8'h00, 32'h1);
        rd(8'h00, d); chk("R8 ctl stays idle", d, 32'h0);
        rd(8'h24, d); chk("R8 status untouched", d, 32'h0);

        // R11 divider and timing upper byte
        wr(8'h28, 32'h8);
        rd(8'h28, d); chk("R11 div reject", d, 32'h4);
        wr(8'h28, 32'h4);
        rd(8'h28, d); chk("R11 div accept", d, 32'h4);
        wr(8'h0C, 32'hFF12_0034);
        rd(8'h0C, d); chk("R11 timing top", d, 32'h0012_0034);

        // power up
        wr(8'h00, 32'h4);

        // R2 R3 directed conversion, level irq (R6)
        wr(8'h20, 32'h8000_0008);
        run_conv(3, 5, 2, 12'hA5C, cyc, irqs);
        chk("R2 busy length", 32'(cyc), 32'(exp_cycles(5, 2)));
        rd(8'h00, d); chk("R2 idle after", d, 32'h4);
        rd(8'h3C, d); chk("R3 result ch3", d, 32'hA5C);
        mirror[3] = 12'hA5C;
        rd(8'h24, d); chk("R3 done ch3", d, 32'h8);
        chk("R6 level irq high", 32'(irq), 32'h1);
        wr(8'h24, 32'h0);
        rd(8'h24, d); chk("R5 write zero keeps", d, 32'h8);
        wr(8'h24, 32'h8);
        rd(8'h24, d); chk("R5 w1c clears", d, 32'h0);
        chk("R6 level irq low", 32'(irq), 32'h0);

        // R2 zero timing gives minimum length
        wr(8'h20, 32'h0);
        run_conv(0, 0, 0, 12'h001, cyc, irqs);
        chk("R2 min length", 32'(cyc), 32'h4);
        mirror[0] = 12'h001;
        wr(8'h24, 32'hFF);

        // R7 pulse irq
        wr(8'h20, 32'h0000_0020);
        run_conv(5, 3, 1, 12'h7F0, cyc, irqs);
        chk("R7 single pulse", 32'(irqs), 32'h1);
        mirror[5] = 12'h7F0;
        wr(8'h24, 32'hFF);

        // R4 bad masks, error interrupt in level mode (R6)
        wr(8'h20, 32'h8001_0000);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h5);
        rd(8'h00, d); chk("R4 zero mask idle", d, 32'h4);
        rd(8'h24, d); chk("R4 err flag", d, 32'h1_0000);
        chk("R6 err irq", 32'(irq), 32'h1);
        wr(8'h24, 32'h1_0000);
        wr(8'h08, 32'h6);
        wr(8'h00, 32'h5);
        rd(8'h00, d); chk("R4 multi mask idle", d, 32'h4);
        rd(8'h24, d); chk("R4 err flag multi", d, 32'h1_0000);
        rd(8'h34, d); chk("R4 result kept", d, 32'(mirror[1]));
        wr(8'h24, 32'h1_0000);
        wr(8'h20, 32'h0);

        // R5 collision: finish and w1c of same bit on one edge
        begin
            int n;
            n = 6;
            wr(8'h08, 32'h4);
            wr(8'h0C, 32'(n));
            ana_in = 12'h3C3;
            wr(8'h00, 32'h5);
            repeat (4 * n - 2) @(negedge clk);
            wr(8'h24, 32'h4);
            rd(8'h24, d); chk("R5 set wins", d, 32'h4);
            rd(8'h38, d); chk("R3 collision result", d, 32'h3C3);
            mirror[2] = 12'h3C3;
            wr(8'h24, 32'hFF);
        end

        // R9 abort
        wr(8'h08, 32'h80);
        wr(8'h0C, 32'd40);
        ana_in = 12'hFFF;
        wr(8'h00, 32'h5);
        repeat (5) @(negedge clk);
        wr(8'h00, 32'h4);
        rd(8'h00, d); chk("R9 stopped", d, 32'h4);
        repeat (200) @(negedge clk);
        rd(8'h24, d); chk("R9 no done", d, 32'h0);
        rd(8'h4C, d); chk("R9 result kept", d, 32'(mirror[7]));

        // random conversions
        for (int k = 0; k < 24; k++) begin
            int ch, smp, cmp;
            logic [11:0] v;
            ch  = int'($urandom % 8);
            smp = int'($urandom % 20);
            cmp = int'($urandom % 8);
            v   = 12'($urandom);
            wr(8'h20, 32'(1) << ch);
            run_conv(ch, smp, cmp, v, cyc, irqs);
            mirror[ch] = v;
            chk("R2 random length", 32'(cyc), 32'(exp_cycles(smp, cmp)));
            rd(8'(8'h30 + 4 * ch), d); chk("R3 random result", d, 32'(v));
            rd(8'h24, d); chk("R3 random done", d, 32'(1) << ch);
            chk("R7 random pulse", 32'(irqs), 32'h1);
            wr(8'h24, 32'(1) << ch);
        end

        // R10 software reset during a conversion
        wr(8'h04, 32'h3015);
        wr(8'h20, 32'h8000_00FF);
        wr(8'h08, 32'h2);
        wr(8'h0C, 32'd50);
        wr(8'h00, 32'h5);
        repeat (3) @(negedge clk);
        wr(8'h00, 32'h8000);
        rd(8'h00, d); chk("R10 ctl", d, 32'h8000);
        rd(8'h04, d); chk("R10 mode", d, 32'h0);
        rd(8'h08, d); chk("R10 mask", d, 32'h0);
        rd(8'h0C, d); chk("R10 timing", d, 32'h000E0578);
        rd(8'h20, d); chk("R10 intc", d, 32'h0);
        rd(8'h30, d); chk("R10 result", d, 32'h0);
        repeat (250) @(negedge clk);
        rd(8'h24, d); chk("R10 no done", d, 32'h0);
        wr(8'h00, 32'h0);
        rd(8'h00, d); chk("R10 bit clears", d, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule